// File: doc/BRIEF.md
# Best-of-Four Synchronizer Selection Controller

This controller calibrates four identical synchronizer slices and chooses the one whose metastability settles fastest. A start pulse clears its event counters and powers every slice. Over a programmable window it counts, for each slice, two kinds of unresolved-event pulses. The first kind is taken at an early sample point and the second at a later one. Each slice's early/late count pair stands for its resolution time constant. The time constant equals the gap between the two sample points divided by the natural log of the early-to-late rate ratio.

The gap is the same for every slice. The fastest slice is therefore the one with the largest early/late ratio. The controller compares these ratios by cross-multiplying, so it needs no divider and no logarithm. When the window closes it latches a 2-bit select for the output multiplexer and raises done. It also powers down the three unused slices and its own counting logic, so that only one synchronizer draws power in operation. Event pulses are digital inputs; the analog behaviour is outside this block.

Top module: `sync_select_ctrl`

## Requirements
- R1: After reset, sel is 0, done is 0, slice_pd is 4'b0000 (all slices powered) and meas_pd is 1.
- R2: A start pulse sampled at a clock edge clears all eight counters, drives done and meas_pd to 0 and slice_pd to 4'b0000 from that edge on. Events counted before the start have no effect on the next selection.
- R3: With window length W (W of at least 1), the pulses sampled at the W edges following the start edge are counted. The result (done=1 and sel) appears after the edge W+1 edges after the start edge, and done stays 0 until then.
- R4: The selected slice i maximises early_i/late_i. Slice a ranks above slice b when early_a*late_b > early_b*late_a.
- R5: A slice with a late count of zero and a nonzero early count ranks above every slice that has a nonzero late count.
- R6: A slice with both counts zero ranks below every other slice. If all slices have zero counts, slice 0 is selected.
- R7: When two or more slices rank equally best, the lowest index is selected.
- R8: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R9: While done is 1, slice_pd has a 1 for each unselected slice and a 0 at bit sel, and meas_pd is 1. sel, done and the power-down outputs hold until the next start.
- R10: A window length of 0 acts as a window of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run |
| win_len | input | WIN_W | Measurement window in cycles, captured at start |
| early_fail | input | NUM_SLICES | Per-slice unresolved pulse at the early sample point |
| late_fail | input | NUM_SLICES | Per-slice unresolved pulse at the later sample point |
| sel | output | SEL_W | Chosen slice for the output multiplexer |
| done | output | 1 | Selection valid and latched |
| slice_pd | output | NUM_SLICES | Per-slice power-down enable |
| meas_pd | output | 1 | Power-down of the measurement logic |

## Verification
A pseudo-random sweep of several hundred runs draws early and late counts of 0 to 7 for every slice. Small values make equal ratios, zero late counts and all-zero slices occur often, which separates the ranking rule from the tie and zero rules. Directed runs target specific cases: counts driven past the counter limit, where wrapping would change the winner, and events injected before a start, where a missing clear would change the winner. Other directed runs cover a one-cycle window from a zero length and a probe of done in the cycle just before the result, which catches an off-by-one window.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_PICK = 2'd2,
    ST_HOLD = 2'd3
  } sel_state_t;
endpackage

// File: rtl/fail_counter.sv
module fail_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             pulse,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && pulse && count != CMAX) begin
      count <= count + 1'b1;
    end
  end

  // R8: a full counter stays full until cleared
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !clr) |=> count == CMAX);
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIN_W-1:0] len,
  input  logic             run,
  output logic             expire
);
  logic [WIN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= (len == '0) ? WIN_W'(1) : len;
    end else if (run && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expire = run && (remain == WIN_W'(1));

  // R3: the timer never sits at zero while the window is running
  a_r3_running_nonzero: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |-> remain != '0);
endmodule

// File: rtl/ratio_better.sv
module ratio_better #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] ea,
  input  logic [CNT_W-1:0] la,
  input  logic [CNT_W-1:0] eb,
  input  logic [CNT_W-1:0] lb,
  output logic             a_wins
);
  localparam int PW = 2 * CNT_W;
  logic [PW-1:0] lhs, rhs;
  logic          a_empty, b_empty;

  assign lhs     = PW'(ea) * PW'(lb);
  assign rhs     = PW'(eb) * PW'(la);
  assign a_empty = (ea == '0) && (la == '0);
  assign b_empty = (eb == '0) && (lb == '0);
  assign a_wins  = !a_empty && (b_empty || (lhs > rhs));
endmodule

// File: rtl/sync_select_ctrl.sv
module sync_select_ctrl #(
  parameter int NUM_SLICES = 4,
  parameter int CNT_W      = 8,
  parameter int WIN_W      = 16,
  localparam int SEL_W     = $clog2(NUM_SLICES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [WIN_W-1:0]      win_len,
  input  logic [NUM_SLICES-1:0] early_fail,
  input  logic [NUM_SLICES-1:0] late_fail,
  output logic [SEL_W-1:0]      sel,
  output logic                  done,
  output logic [NUM_SLICES-1:0] slice_pd,
  output logic                  meas_pd
);
  import sync_sel_pkg::*;

  sel_state_t        state;
  logic              counting;
  logic              win_end;
  logic [CNT_W-1:0]  e_cnt [NUM_SLICES];
  logic [CNT_W-1:0]  l_cnt [NUM_SLICES];
  logic [SEL_W-1:0]  lead  [NUM_SLICES];

  assign counting = (state == ST_MEAS) && !start;

  window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst(rst), .load(start), .len(win_len),
    .run(counting), .expire(win_end)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    fail_counter #(.CNT_W(CNT_W)) u_early (
      .clk(clk), .rst(rst), .clr(start), .en(counting),
      .pulse(early_fail[s]), .count(e_cnt[s])
    );
    fail_counter #(.CNT_W(CNT_W)) u_late (
      .clk(clk), .rst(rst), .clr(start), .en(counting),
      .pulse(late_fail[s]), .count(l_cnt[s])
    );
  end

  // linear scan: a later slice replaces the leader only when strictly better
  assign lead[0] = '0;
  for (genvar s = 1; s < NUM_SLICES; s++) begin : g_scan
    logic s_wins;
    ratio_better #(.CNT_W(CNT_W)) u_cmp (
      .ea(e_cnt[s]), .la(l_cnt[s]),
      .eb(e_cnt[lead[s-1]]), .lb(l_cnt[lead[s-1]]),
      .a_wins(s_wins)
    );
    assign lead[s] = s_wins ? SEL_W'(s) : lead[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel      <= '0;
      done     <= 1'b0;
      slice_pd <= '0;
      meas_pd  <= 1'b1;
    end else if (start) begin
      state    <= ST_MEAS;
      done     <= 1'b0;
      slice_pd <= '0;
      meas_pd  <= 1'b0;
    end else begin
      case (state)
        ST_MEAS: if (win_end) state <= ST_PICK;
        ST_PICK: begin
          state    <= ST_HOLD;
          sel      <= lead[NUM_SLICES-1];
          done     <= 1'b1;
          meas_pd  <= 1'b1;
          slice_pd <= ~(NUM_SLICES'(1) << lead[NUM_SLICES-1]);
        end
        default: state <= state;
      endcase
    end
  end

  // R2: a start drops done and powers everything up
  a_r2_start_wakes: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && slice_pd == '0 && !meas_pd));
  // R9: exactly one slice stays powered, and it is the selected one
  a_r9_one_alive: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(~slice_pd) == 1 && !slice_pd[sel] && meas_pd));
  // R9: result holds until a new start
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(sel) && $stable(slice_pd)));
  // R3: done only rises out of the decision step
  a_r3_done_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state == ST_PICK));
endmodule

// File: tb/sync_select_ctrl_test.sv
module sync_select_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int CW   = 4;
  localparam int WW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst = 1;
  logic          start = 0;
  logic [WW-1:0] win_len = '0;
  logic [NS-1:0] early_fail = '0;
  logic [NS-1:0] late_fail = '0;
  logic [1:0]    sel;
  logic          done;
  logic [NS-1:0] slice_pd;
  logic          meas_pd;

  int compared = 0;
  int mismatched = 0;
  int te [NS];
  int tl [NS];
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_select_ctrl #(.NUM_SLICES(NS), .CNT_W(CW), .WIN_W(WW)) uut (
    .clk(clk), .rst(rst), .start(start), .win_len(win_len),
    .early_fail(early_fail), .late_fail(late_fail),
    .sel(sel), .done(done), .slice_pd(slice_pd), .meas_pd(meas_pd)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // ranking from R4..R7: nonempty beats empty, else larger early/late wins
  function automatic bit beats(input int a, input int b);
    int ea, la, eb, lb;
    ea = sat(te[a]); la = sat(tl[a]); eb = sat(te[b]); lb = sat(tl[b]);
    if (ea == 0 && la == 0) return 0;
    if (eb == 0 && lb == 0) return 1;
    return (ea * lb) > (eb * la);
  endfunction

  function automatic int expect_sel();
    int best = 0;
    for (int i = 1; i < NS; i++) if (beats(i, best)) best = i;
    return best;
  endfunction

  // start at one edge, then drive te/tl pulses over nw window edges
  task automatic run(input int wl, input int nw, input string req);
    int exp_s;
    @(negedge clk);
    start = 1; win_len = WW'(wl);
    @(negedge clk);
    start = 0;
    for (int j = 1; j <= nw; j++) begin
      for (int s = 0; s < NS; s++) begin
        early_fail[s] = (j <= te[s]);
        late_fail[s]  = (j <= tl[s]);
      end
      @(negedge clk);
      if (j == nw) check({req, " R3 done low before result"}, int'(done), 0);
    end
    early_fail = '0; late_fail = '0;
    @(negedge clk);
    exp_s = expect_sel();
    check({req, " R3 done"}, int'(done), 1);
    check({req, " sel"}, int'(sel), exp_s);
    check({req, " R9 slice_pd"}, int'(slice_pd), int'(~(4'b1 << exp_s) & 4'hF));
    check({req, " R9 meas_pd"}, int'(meas_pd), 1);
  endtask

  task automatic set4(input int e0, l0, e1, l1, e2, l2, e3, l3);
    te[0] = e0; tl[0] = l0; te[1] = e1; tl[1] = l1;
    te[2] = e2; tl[2] = l2; te[3] = e3; tl[3] = l3;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sel", int'(sel), 0);
    check("R1 done", int'(done), 0);
    check("R1 slice_pd", int'(slice_pd), 0);
    check("R1 meas_pd", int'(meas_pd), 1);

    // R2 wake-up values right after a start
    @(negedge clk); start = 1; win_len = 8'd4;
    @(negedge clk); start = 0;
    check("R2 done", int'(done), 0);
    check("R2 meas_pd", int'(meas_pd), 0);
    check("R2 slice_pd", int'(slice_pd), 0);
    repeat (6) @(negedge clk);

    // R4 plain ratio: slice 2 has 6/1
    set4(4, 2, 3, 3, 6, 1, 5, 2);  run(8, 8, "R4 ratio");
    // R5 zero late wins over large ratio
    set4(7, 1, 1, 0, 7, 1, 0, 3);  run(8, 8, "R5 zero late");
    // R5+R7 two zero-late slices: lower index
    set4(2, 2, 0, 1, 1, 0, 5, 0);  run(8, 8, "R7 infinite tie");
    // R6 all empty
    set4(0, 0, 0, 0, 0, 0, 0, 0);  run(8, 8, "R6 all zero");
    // R6 empty slice 0 loses to ratio zero slice 3
    set4(0, 0, 0, 0, 0, 0, 0, 4);  run(8, 8, "R6 empty loses");
    // R7 equal ratios 2/1 == 4/2 on slices 1 and 3
    set4(1, 1, 2, 1, 1, 2, 4, 2);  run(8, 8, "R7 ratio tie");
    // R8 saturation: slice 0 early 20 -> 15 beats slice 1 at 14
    set4(20, 1, 14, 1, 1, 1, 0, 1); run(20, 20, "R8 saturate");

    // R9 hold while idle after done, with pulses present
    early_fail = 4'b1000; late_fail = 4'b0000;
    repeat (10) @(negedge clk);
    check("R9 hold done", int'(done), 1);
    check("R9 hold sel", int'(sel), 0);
    check("R9 hold slice_pd", int'(slice_pd), 4'b1110);
    early_fail = '0;
    // R2 stale events on slice 3 must not carry into this run
    set4(3, 1, 1, 1, 1, 1, 0, 0);  run(8, 8, "R2 clear");

    // R10 zero length window counts exactly one edge
    set4(0, 0, 0, 0, 1, 0, 0, 0);  run(0, 1, "R10 zero window");

    // sweep of R4..R7 with small counts
    for (int t = 0; t < 400; t++) begin
      for (int s = 0; s < NS; s++) begin
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        te[s] = int'(rng[2:0]);
        tl[s] = int'(rng[6:4]);
        if (t % 5 == 0) tl[s] = 0;
      end
      run(8, 8, "R4 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule